// File: doc/BRIEF.md
# Burst Master Port Handshake Controller

This block sits on the sending side of a link between two locally synchronous domains that move data in long bursts. When the local logic raises its burst enable, the controller opens a four-phase request/acknowledge exchange with the receiving port. While it waits for the grant, it holds a pause request toward its own clock source. Once the grant is seen, it releases the pause and reports the burst as active. From that point every local clock cycle carries a data word, and the handshake is not repeated per word. When the enable falls, the request is withdrawn. A new burst cannot open until the receiver has withdrawn its acknowledge.

Everything is modelled on one fast reference clock. The local clock of the domain is a tick enable: the block takes in a free-running tick and passes out a gated tick. The gated tick is suppressed in every cycle in which the pause is held. The acknowledge comes from the other domain, so it passes through a synchronizer with a parameter-set number of flops before the state machine sees it. No data path is part of this block. The gated tick is the beat strobe for whatever data path sits beside it.

Top module: `burst_master_port`

## Requirements
- R1: A reference clock edge with `rst_n` low puts the controller in the idle state: `burst_req_o`, `clk_pause_o` and `burst_active_o` are all low, and the gated tick follows the free-running tick.
- R2: In idle, with the synchronized acknowledge low, a high `burst_en_i` sampled at one edge drives `burst_req_o` and `clk_pause_o` high from that edge on.
- R3: `loc_tick_o` equals `loc_tick_i` AND NOT `clk_pause_o` in every cycle. No local tick passes between the rise of the request and the registered grant.
- R4: The pause stays high until the acknowledge is seen. With `ACK_SYNC_STAGES`=S, an acknowledge that rises before edge 1 clears `clk_pause_o` and sets `burst_active_o` at edge S+1, and not earlier.
- R5: During the active burst, `burst_req_o` stays high and every local tick passes unchanged. Each burst raises `burst_req_o` exactly once.
- R6: In the active burst, a low `burst_en_i` sampled at an edge drops `burst_req_o` and `burst_active_o` at that edge.
- R7: After the request drops, a `burst_en_i` held high does not raise a new request while the acknowledge is still high. An acknowledge that falls before edge 1 lets the new request rise at edge S+1, with no pass through idle.
- R8: A `burst_en_i` that falls while the grant is pending does not withdraw the request. The controller waits for the grant, is active for exactly one cycle, and then drops the request.
- R9: In idle, a high acknowledge blocks the start of a burst. With `burst_en_i` high, the request rises at edge S+1 after the acknowledge falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loc_tick_i | input | 1 | Free-running local clock tick |
| burst_en_i | input | 1 | Burst enable from local logic |
| slv_ack_i | input | 1 | Acknowledge from the receiving port (asynchronous) |
| burst_req_o | output | 1 | Request toward the receiving port |
| clk_pause_o | output | 1 | Pause request to the local clock source |
| burst_active_o | output | 1 | Burst granted; every gated tick is a data beat |
| loc_tick_o | output | 1 | Gated local tick |

## Verification
The enable path is one register deep, so request, pause and release changes are due one edge after the enable is sampled. Any acknowledge change goes through S synchronizer flops plus the state register, so results that depend on it are due at edge S+1. The gated tick is combinational from the state and is compared in the same cycle. Inputs are driven just after a falling edge and outputs are sampled at the falling edges that these latencies predict. The bench also checks one edge before each predicted change, to show that nothing arrives early. A sweep over grant delays and burst lengths counts request rises, to confirm one handshake per burst.

// File: rtl/burst_master_pkg.sv
package burst_master_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQUEST = 2'd1,
    ST_BURST   = 2'd2,
    ST_RELEASE = 2'd3
  } bm_state_t;

endpackage

// File: rtl/bm_ack_sync.sv
module bm_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], async_i} & {STAGES{1'b1}};
      end
      assign sync_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/bm_fsm.sv
module bm_fsm
  import burst_master_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic burst_en_i,
  input  logic ack_s_i,
  output logic req_o,
  output logic pause_o,
  output logic active_o
);

  bm_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (burst_en_i && !ack_s_i) state_d = ST_REQUEST;
      ST_REQUEST: if (ack_s_i)                state_d = ST_BURST;
      ST_BURST:   if (!burst_en_i)            state_d = ST_RELEASE;
      ST_RELEASE: if (!ack_s_i)               state_d = burst_en_i ? ST_REQUEST : ST_IDLE;
      default:                                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_o    = (state_q == ST_REQUEST) || (state_q == ST_BURST);
  assign pause_o  = (state_q == ST_REQUEST);
  assign active_o = (state_q == ST_BURST);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!req_o && !pause_o && !active_o)); // R1

  AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && burst_en_i && !ack_s_i) |=> (req_o && pause_o)); // R2

  AST_PAUSE_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_o && !ack_s_i) |=> (pause_o && req_o)); // R4

  AST_GRANT_ENDS_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_o && ack_s_i) |=> (active_o && !pause_o)); // R4

  AST_REQ_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && burst_en_i) |=> (active_o && req_o)); // R5

  AST_DROP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !burst_en_i) |=> (!req_o && !active_o)); // R6

  AST_NEW_REQ_NEEDS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> !$past(ack_s_i)); // R7

  AST_IDLE_BLOCKED_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && ack_s_i) |=> !req_o); // R9

endmodule

// File: rtl/bm_tick_gate.sv
module bm_tick_gate (
  input  logic tick_i,
  input  logic pause_i,
  output logic tick_o
);

  assign tick_o = tick_i & ~pause_i;

endmodule

// File: rtl/burst_master_port.sv
module burst_master_port #(
  parameter int ACK_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_tick_i,
  input  logic burst_en_i,
  input  logic slv_ack_i,
  output logic burst_req_o,
  output logic clk_pause_o,
  output logic burst_active_o,
  output logic loc_tick_o
);

  logic ack_s;

  bm_ack_sync #(.STAGES(ACK_SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (slv_ack_i),
    .sync_o  (ack_s)
  );

  bm_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .burst_en_i (burst_en_i),
    .ack_s_i    (ack_s),
    .req_o      (burst_req_o),
    .pause_o    (clk_pause_o),
    .active_o   (burst_active_o)
  );

  bm_tick_gate u_tick_gate (
    .tick_i  (loc_tick_i),
    .pause_i (clk_pause_o),
    .tick_o  (loc_tick_o)
  );

  AST_NO_TICK_WHILE_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pause_o |-> !loc_tick_o); // R3

  AST_PAUSE_IMPLIES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pause_o |-> (burst_req_o && !burst_active_o)); // R4

endmodule

// File: tb/test_burst_master_port.sv
module test_burst_master_port;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic en = 1'b0;
  logic ack = 1'b0;
  logic req, pause, active, tick_o;

  int checks = 0;
  int errors = 0;
  int req_rises = 0;
  int cyc = 0;
  logic req_d = 1'b0;

  always #4 clk = ~clk;

  burst_master_port #(.ACK_SYNC_STAGES(SYNC)) i_burst_master_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .loc_tick_i     (tick_i),
    .burst_en_i     (en),
    .slv_ack_i      (ack),
    .burst_req_o    (req),
    .clk_pause_o    (pause),
    .burst_active_o (active),
    .loc_tick_o     (tick_o)
  );

  always @(posedge clk) begin
    req_d <= req;
    if (rst_n && req && !req_d) req_rises <= req_rises + 1;
    cyc <= cyc + 1;
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      finish_run();
    end
  end

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {28'd0, req, pause, active, tick_o};
  endfunction

  task automatic do_burst(input int g, input int len);
    int r0;
    r0 = req_rises;
    en = 1'b1; tick_i = 1'b1;
    nstep(1);
    chk(req === 1'b1 && pause === 1'b1, "R2 request and pause after enable", outs(), 4'b1100);
    for (int k = 0; k < g; k++) begin
      nstep(1);
      chk(pause === 1'b1 && tick_o === 1'b0, "R3 tick suppressed while paused", outs(), 4'b1100);
    end
    ack = 1'b1;
    nstep(SYNC);
    chk(pause === 1'b1 && tick_o === 1'b0, "R4 pause held during ack sync", outs(), 4'b1100);
    nstep(1);
    chk(pause === 1'b0 && active === 1'b1, "R4 grant at edge S+1", outs(), 4'b1011);
    for (int i = 0; i < len; i++) begin
      tick_i = (i % 3) != 2;
      #1;
      chk(tick_o === tick_i && req === 1'b1 && active === 1'b1, "R5 ticks pass in burst",
          outs(), {req, 1'b0, 1'b1, tick_i});
      nstep(1);
    end
    en = 1'b0; tick_i = 1'b1;
    nstep(1);
    chk(req === 1'b0 && active === 1'b0 && tick_o === 1'b1, "R6 drop on enable fall", outs(), 4'b0001);
    ack = 1'b0;
    nstep(SYNC + 1);
    chk(req === 1'b0 && pause === 1'b0, "R6 idle after release", outs(), 4'b0001);
    chk(req_rises == r0 + 1, "R5 one handshake per burst", req_rises - r0, 1);
  endtask

  initial begin
    nstep(2);
    tick_i = 1'b1; #1;
    chk(req === 1'b0 && pause === 1'b0 && active === 1'b0 && tick_o === 1'b1,
        "R1 reset state", outs(), 4'b0001);
    rst_n = 1'b1;
    nstep(1);

    for (int g = 0; g < 4; g++)
      for (int len = 1; len < 6; len++)
        do_burst(g, len);

    // R7 back-to-back: enable re-raised while ack still high
    begin
      int r0;
      r0 = req_rises;
      en = 1'b1; nstep(1);
      ack = 1'b1; nstep(SYNC + 1);
      chk(active === 1'b1, "R7 first burst active", outs(), 4'b1011);
      en = 1'b0; nstep(1);
      en = 1'b1;
      for (int k = 0; k < 3; k++) begin
        nstep(1);
        chk(req === 1'b0, "R7 no request while ack high", outs(), 4'b0001);
      end
      ack = 1'b0;
      nstep(SYNC);
      chk(req === 1'b0, "R7 not early after ack fall", outs(), 4'b0001);
      nstep(1);
      chk(req === 1'b1 && pause === 1'b1, "R7 new request at S+1", outs(), 4'b1100);
      ack = 1'b1; nstep(SYNC + 1);
      chk(active === 1'b1, "R7 second burst active", outs(), 4'b1011);
      en = 1'b0; nstep(1);
      ack = 1'b0; nstep(SYNC + 1);
      chk(req_rises == r0 + 2, "R7 two bursts two handshakes", req_rises - r0, 2);
    end

    // R8 enable withdrawn while grant pending
    en = 1'b1; nstep(1);
    en = 1'b0; nstep(2);
    chk(req === 1'b1 && pause === 1'b1, "R8 request kept after early enable fall", outs(), 4'b1100);
    ack = 1'b1; nstep(SYNC + 1);
    chk(active === 1'b1, "R8 one active cycle", outs(), 4'b1011);
    nstep(1);
    chk(req === 1'b0 && active === 1'b0, "R8 request dropped after one cycle", outs(), 4'b0001);
    ack = 1'b0; nstep(SYNC + 1);

    // R9 stale ack in idle blocks start
    ack = 1'b1; nstep(SYNC + 1);
    en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      nstep(1);
      chk(req === 1'b0 && pause === 1'b0 && tick_o === 1'b1, "R9 idle held by high ack", outs(), 4'b0001);
    end
    ack = 1'b0;
    nstep(SYNC);
    chk(req === 1'b0, "R9 not early after ack fall", outs(), 4'b0001);
    nstep(1);
    chk(req === 1'b1 && pause === 1'b1, "R9 request at S+1", outs(), 4'b1100);

    // R1 reset in the middle of a pending request
    rst_n = 1'b0; en = 1'b0; nstep(1);
    chk(req === 1'b0 && pause === 1'b0 && active === 1'b0, "R1 reset mid-request", outs(), 4'b0001);
    rst_n = 1'b1; nstep(2);

    finish_run();
  end

endmodule